// File: doc/BRIEF.md
# Accumulator Stored-Program Machine

This block is a compact stored-program processor built around a single accumulator. It holds a program counter, a memory address register, an instruction register, a data register, the accumulator with a one-bit extension (carry) flag, a cycle-type flag that separates instruction fetch from execution, and a run flag. A two-bit step counter times the register transfers inside each cycle. Program and data share one internal synchronous word array with a one-cycle read latency.

Before a run, the array is filled through a load port while the machine is stopped. A one-cycle `run` pulse starts execution at the current program counter. The machine stops itself on a halt instruction. Software-visible results are the accumulator, the extension flag, the program counter and, through a second registered read port, any memory word.

Each instruction word carries a 4-bit opcode in its top bits and a direct address in its low bits. The supported operations are logical AND into the accumulator, add to the accumulator, store the accumulator, increment memory and skip if the result is zero, unconditional branch, branch to subroutine, and halt.

Top module: `acc_machine`

## Requirements
- R1: A fetch takes three cycles. Step 0 copies PC into the address register. Step 1 loads the instruction register with the word at that address and adds one to PC. Step 2 sets the cycle-type flag.
- R2: With the cycle-type flag set, one execute cycle follows. ISZ uses two execute cycles. Execution then clears the flag and the step counter. An instruction other than ISZ therefore occupies four cycles while running.
- R3: A `run` pulse while stopped sets the run flag. While the flag is clear, PC, the accumulator and the extension flag hold their values. Load-port writes take effect only while the machine is stopped.
- R4: Opcode 0 (AND) replaces the accumulator with its bitwise AND with the addressed word.
- R5: Opcode 1 (ADD) adds the addressed word to the accumulator. The carry out goes to the extension flag. AND and STA leave the extension flag unchanged.
- R6: Opcode 2 (STA) writes the accumulator to the addressed word.
- R7: Opcode 3 (ISZ) writes the addressed word plus one back to that word. If the new value is zero, PC is advanced once more, so the next instruction is skipped.
- R8: Opcode 4 (BUN) loads PC with the address field.
- R9: Opcode 5 (BSB) writes the return address (PC after fetch, zero-extended) into the addressed word. It then loads PC with that address plus one.
- R10: Opcode 15 (HLT) clears the run flag. PC is left pointing one past the halt instruction.
- R11: The opcode is taken from bits 15:12 and the effective address from the low ADDR_W bits of the word. Opcodes 6 to 14 complete a normal four-cycle instruction and change no register other than PC's normal increment.
- R12: After reset the run flag, cycle-type flag, PC, accumulator and extension flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start pulse, honoured while stopped |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | ADDR_W | Load-port word address |
| ld_data | input | WORD_W | Load-port write data |
| peek_addr | input | ADDR_W | Inspection read address |
| peek_data | output | WORD_W | Inspection read data, one cycle after the address |
| running | output | 1 | Run flag |
| acc | output | WORD_W | Accumulator |
| ext | output | 1 | Accumulator extension flag |
| pc | output | ADDR_W | Program counter |

## Verification
A wrong step count or a stuck cycle-type flag changes how many cycles `running` stays high for a known program, so the bench counts those cycles for every run. A bad PC increment, a missed skip or a wrong branch target leads to the wrong final PC or to a wrong loop count. Such an error appears within the same run, because each program ends with a halt at a known address. Errors in the data path appear at the final accumulator and extension values, or in memory words read back through the inspection port after the halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int OPC_W = 4;
   localparam logic [OPC_W-1:0] OPC_AND = 4'h0;
   localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
   localparam logic [OPC_W-1:0] OPC_STA = 4'h2;
   localparam logic [OPC_W-1:0] OPC_ISZ = 4'h3;
   localparam logic [OPC_W-1:0] OPC_BUN = 4'h4;
   localparam logic [OPC_W-1:0] OPC_BSB = 4'h5;
   localparam logic [OPC_W-1:0] OPC_HLT = 4'hF;
   localparam int SC_W = 2;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata,
   input  logic [ADDR_W-1:0] paddr,
   output logic [WORD_W-1:0] pdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
      pdata <= cells[paddr];
   end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            halt_req,
   input  logic            exec_end,
   output logic            s_q,
   output logic            f_q,
   output logic [SC_W-1:0] sc_q
);
   localparam logic [SC_W-1:0] FETCH_LAST = SC_W'(2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q  <= 1'b0;
         f_q  <= 1'b0;
         sc_q <= '0;
      end else if (!s_q) begin
         if (run) begin
            s_q  <= 1'b1;
            f_q  <= 1'b0;
            sc_q <= '0;
         end
      end else begin
         if (halt_req) s_q <= 1'b0;
         if (!f_q && sc_q == FETCH_LAST) begin
            f_q  <= 1'b1;
            sc_q <= '0;
         end else if (f_q && exec_end) begin
            f_q  <= 1'b0;
            sc_q <= '0;
         end else begin
            sc_q <= sc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/acc_machine.sv
module acc_machine
   import acc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ld_we,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [WORD_W-1:0] peek_data,
   output logic              running,
   output logic [WORD_W-1:0] acc,
   output logic              ext,
   output logic [ADDR_W-1:0] pc
);
   localparam int FIELD_W = WORD_W - OPC_W;
   localparam int PAD_W   = WORD_W - ADDR_W;

   if (ADDR_W > FIELD_W) begin : g_bad_addr
      $error("ADDR_W must fit in the address field");
   end
   if (FIELD_W < 1) begin : g_bad_word
      $error("WORD_W too small for the opcode");
   end

   logic              s_q, f_q;
   logic [SC_W-1:0]   sc_q;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [WORD_W-1:0] ir_q, a_q, dr_q;
   logic              e_q;
   logic [WORD_W-1:0] rdata;
   logic [OPC_W-1:0]  opc;
   logic [ADDR_W-1:0] ea;
   logic              fetch, t0, t1, t2, exec_end, halt_req;
   logic              cpu_we, mem_we;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [WORD_W-1:0] cpu_wdata, mem_wdata;
   logic [WORD_W:0]   sum;

   assign opc   = ir_q[WORD_W-1 -: OPC_W];
   assign ea    = ir_q[ADDR_W-1:0];
   assign fetch = s_q && !f_q;
   assign t0    = sc_q == SC_W'(0);
   assign t1    = sc_q == SC_W'(1);
   assign t2    = sc_q == SC_W'(2);
   assign sum   = {1'b0, a_q} + {1'b0, rdata};

   always_comb begin
      exec_end = f_q && ((opc == OPC_ISZ) ? t1 : t0);
      halt_req = f_q && t0 && (opc == OPC_HLT);
      cpu_we   = s_q && f_q && ((t0 && (opc == OPC_STA || opc == OPC_BSB))
                                || (t1 && opc == OPC_ISZ));
      case (opc)
         OPC_STA: cpu_wdata = a_q;
         OPC_BSB: cpu_wdata = {{PAD_W{1'b0}}, pc_q};
         default: cpu_wdata = dr_q;
      endcase
      if (fetch && t0)      mem_raddr = pc_q;
      else if (fetch && t2) mem_raddr = ea;
      else                  mem_raddr = mar_q;
      mem_we    = s_q ? cpu_we : ld_we;
      mem_waddr = s_q ? mar_q  : ld_addr;
      mem_wdata = s_q ? cpu_wdata : ld_data;
   end

   acc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .run(run), .halt_req(halt_req),
      .exec_end(exec_end), .s_q(s_q), .f_q(f_q), .sc_q(sc_q)
   );

   acc_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(rdata), .paddr(peek_addr), .pdata(peek_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         ir_q  <= '0;
         a_q   <= '0;
         dr_q  <= '0;
         e_q   <= 1'b0;
      end else if (fetch) begin
         if (t0) mar_q <= pc_q;
         if (t1) begin
            ir_q <= rdata;
            pc_q <= pc_q + 1'b1;
         end
         if (t2) mar_q <= ea;
      end else if (s_q) begin
         if (t0) begin
            case (opc)
               OPC_AND: a_q <= a_q & rdata;
               OPC_ADD: {e_q, a_q} <= sum;
               OPC_ISZ: dr_q <= rdata + 1'b1;
               OPC_BUN: pc_q <= mar_q;
               OPC_BSB: pc_q <= mar_q + 1'b1;
               default: ;
            endcase
         end
         if (t1 && opc == OPC_ISZ && dr_q == '0) pc_q <= pc_q + 1'b1;
      end
   end

   assign running = s_q;
   assign acc     = a_q;
   assign ext     = e_q;
   assign pc      = pc_q;
endmodule

// File: rtl/acc_checker.sv
module acc_checker
   import acc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_q,
   input logic              f_q,
   input logic [SC_W-1:0]   sc_q,
   input logic [OPC_W-1:0]  opc,
   input logic [ADDR_W-1:0] pc,
   input logic [WORD_W-1:0] acc,
   input logic              ext
);
   assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !s_q |=> ($stable(pc) && $stable(acc) && $stable(ext)));

   assert_fetch_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && !f_q) |-> (sc_q <= SC_W'(2)));

   assert_pc_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && !f_q && sc_q == SC_W'(1)) |=> (pc == $past(pc) + 1'b1));

   assert_exec_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && $rose(f_q)) |-> ($past(sc_q) == SC_W'(2)));

   assert_second_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (f_q && sc_q == SC_W'(1)) |-> (opc == OPC_ISZ));

   assert_halt_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(s_q) |-> ($past(opc) == OPC_HLT && $past(f_q)));
endmodule

bind acc_machine acc_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_q(s_q), .f_q(f_q), .sc_q(sc_q),
   .opc(opc), .pc(pc), .acc(acc), .ext(ext)
);

// File: tb/acc_machine_test.sv
module acc_machine_test;
   localparam int AW = 8;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [WW-1:0] ld_data = '0;
   logic [AW-1:0] peek_addr = '0;
   logic [WW-1:0] peek_data;
   logic          running;
   logic [WW-1:0] acc;
   logic          ext;
   logic [AW-1:0] pc;

   int checks = 0;
   int fails = 0;
   int cyc;

   always #2 clk = ~clk;

   acc_machine #(.ADDR_W(AW), .WORD_W(WW)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
      .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
      .running(running), .acc(acc), .ext(ext), .pc(pc)
   );

   function automatic logic [WW-1:0] ins(input logic [3:0] op, input int adr);
      return {op, 12'(adr)};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int adr, input logic [WW-1:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(adr); ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic peek(input int adr, output logic [WW-1:0] d);
      @(negedge clk);
      peek_addr = AW'(adr);
      @(negedge clk);
      d = peek_data;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic go();
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      run = 1'b0;
      cyc = 0;
      while (running && cyc < 3000) begin
         cyc++;
         @(negedge clk);
      end
      if (cyc >= 3000) begin
         fails++;
         $display("FAIL watchdog run did not halt actual=%0d expected=<3000", cyc);
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL global watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [WW-1:0] d, x, y, c0;
      logic [WW:0]   s2;
      do_reset();
      // R12 reset state
      chk("R12 running", 32'(running), 0);
      chk("R12 pc", 32'(pc), 0);
      chk("R12 acc", 32'(acc), 0);
      chk("R12 ext", 32'(ext), 0);

      // R4 R5 R6: add sweep; E survives AND and STA
      for (int i = 0; i < 14; i++) begin
         x = (i == 12) ? 16'h8000 : (i == 13) ? 16'hFFFF : 16'(i * 13107 + 1);
         y = (i == 12) ? 16'h8000 : (i == 13) ? 16'hFFFF : 16'(16'hFFFF - i * 4369);
         s2 = {1'b0, x} + {1'b0, y};
         wr(0, ins(4'h0, 'h20));
         wr(1, ins(4'h1, 'h21));
         wr(2, ins(4'h1, 'h22));
         wr(3, ins(4'h2, 'h23));
         wr(4, ins(4'h0, 'h20));
         wr(5, ins(4'hF, 0));
         wr('h20, 16'h0000);
         wr('h21, x);
         wr('h22, y);
         do_reset();
         go();
         chk("R2 cycle count add program", 32'(cyc), 24);
         chk("R10 pc after halt", 32'(pc), 6);
         chk("R5 carry kept through AND/STA", 32'(ext), 32'(s2[WW]));
         chk("R4 acc after AND zero", 32'(acc), 0);
         peek('h23, d);
         chk("R6 stored sum", 32'(d), 32'(s2[WW-1:0]));
         chk("R3 stopped after halt", 32'(running), 0);
      end

      // R4: AND of two operands
      for (int i = 0; i < 8; i++) begin
         x = 16'(16'hF0F0 ^ (i * 4681));
         y = 16'(16'h3C3C + i * 257);
         wr(0, ins(4'h0, 'h20));
         wr(1, ins(4'h1, 'h21));
         wr(2, ins(4'h0, 'h22));
         wr(3, ins(4'hF, 0));
         wr('h21, x);
         wr('h22, y);
         do_reset();
         go();
         chk("R4 and result", 32'(acc), 32'(x & y));
         chk("R2 cycle count and program", 32'(cyc), 16);
      end

      // R7 R8: ISZ counting loop with start values -1..-4
      for (int k = 1; k <= 4; k++) begin
         c0 = 16'(-k);
         wr(0, ins(4'h3, 'h30));
         wr(1, ins(4'h4, 0));
         wr(2, ins(4'hF, 0));
         wr('h30, c0);
         do_reset();
         go();
         chk("R7 pc after skip", 32'(pc), 3);
         chk("R7 R8 loop cycles", 32'(cyc), 5 * k + 4 * (k - 1) + 4);
         peek('h30, d);
         chk("R7 counter written back", 32'(d), 0);
      end
      // R7: non-zero result does not skip (start 5 -> 6, then BUN skips past)
      wr(0, ins(4'h3, 'h30));
      wr(1, ins(4'h4, 3));
      wr(2, ins(4'hF, 0));
      wr(3, ins(4'hF, 0));
      wr('h30, 16'd5);
      do_reset();
      go();
      chk("R7 R8 no skip then branch", 32'(pc), 4);
      peek('h30, d);
      chk("R7 incremented word", 32'(d), 6);

      // R9 R11: subroutine call and undefined opcode as no-op
      wr(0, ins(4'h5, 'h40));
      wr(1, ins(4'hF, 0));
      wr('h40, 16'h0000);
      wr('h41, ins(4'h0, 'h20));
      wr('h42, ins(4'h1, 'h21));
      wr('h43, ins(4'h7, 'h21));
      wr('h44, ins(4'hF, 0));
      wr('h20, 16'h0000);
      wr('h21, 16'h1234);
      do_reset();
      go();
      chk("R9 R11 pc after subroutine", 32'(pc), 'h45);
      chk("R11 acc untouched by opcode 7", 32'(acc), 'h1234);
      chk("R2 cycle count call program", 32'(cyc), 20);
      peek('h40, d);
      chk("R9 return address saved", 32'(d), 1);

      // R11: address field uses low bits only (bit 8 set in field)
      wr(0, ins(4'h1, 'h121));
      wr(1, ins(4'hF, 0));
      do_reset();
      go();
      chk("R11 address low bits", 32'(acc), 'h1234);

      // R3: registers hold while stopped, loader works while stopped
      repeat (10) @(negedge clk);
      chk("R3 pc held", 32'(pc), 2);
      chk("R3 acc held", 32'(acc), 'h1234);
      wr('h50, 16'hBEEF);
      peek('h50, d);
      chk("R3 loader write while stopped", 32'(d), 'hBEEF);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule